// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the software-visible face of a serial port. A CPU reaches it over a simple word-addressed bus that has a byte address, read and write strobes, write data and combinational read data. Received bytes arrive on a valid/byte input and are queued in a small receive FIFO. Software drains that FIFO by reading the data word. Each write to the data word sends its low byte out on a one-cycle transmit strobe.

The block holds a latched raw interrupt status, a mask and a write-one-to-clear port. It drives a single level interrupt that is high whenever any unmasked status bit is set. The baud-divisor, line, control, FIFO-level, low-power and DMA words are stored and read back, with no effect on behaviour. The top of the 4 KB window returns fixed identification bytes. All serial bit timing lives outside this block.

Top module: `uart_regif`

## Requirements
- R1: After reset the flag word (0x18) reads 0x90, which is the transmit-empty flag (bit 7) plus the receive-empty flag (bit 4). The raw status (0x3C), mask (0x38), masked status (0x40) and every stored configuration word read 0. `irq` and `tx_valid` are low.
- R2: Seven configuration words at 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 and 0x48 each store all 32 written bits and read them back unchanged.
- R3: The receive FIFO holds 16 bytes. A byte that arrives while it holds 16 is dropped. Flag bit 6 reads 1 exactly while the FIFO holds 16 bytes.
- R4: An accepted received byte clears flag bit 4 and sets raw status bit 4 (receive).
- R5: A read of 0x00 returns the oldest byte and removes it, so bytes come out in arrival order. A read while the FIFO is empty returns 0. A read that empties the FIFO sets flag bit 4 and clears raw status bit 4.
- R6: A write to 0x00 raises `tx_valid` for exactly one cycle, starting at the next clock edge, with `tx_byte` equal to the written bits 7:0. It also sets raw status bit 5 (transmit), and flag bit 7 stays 1.
- R7: A write to 0x38 keeps bits 10:0 as the mask and drops the rest. A read of 0x40 returns the raw status ANDed with the mask.
- R8: A write to 0x44 clears each raw status bit written as 1 in bits 10:0 and ignores bits above 10. 0x44 reads 0. A receive-bit set in the same cycle as its clear wins.
- R9: From the cycle after any change of raw status or mask, `irq` equals the OR of (raw status AND mask). A mask of 0 forces `irq` low.
- R10: Writes to 0x18, 0x3C and 0x40 change nothing. 0x04 reads 0, and writing it has no visible effect.
- R11: Offsets 0xFE0 to 0xFEC read 0x11, 0x10, 0x14 and 0x00, and offsets 0xFF0 to 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1. Unmapped offsets and any address whose bits 1:0 are nonzero read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe; a data-word read pops at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs a long seeded random interleaving of byte arrivals, data reads, data writes, mask writes and clear writes against a bench model. After every operation it compares the FIFO order, the flags, the raw status and `irq`. This separates ordering faults from flag and interrupt-timing faults. Directed passes cover the remaining cases:
- filling the FIFO past 16 entries, which shows whether the overflow byte is dropped or corrupts the queue;
- reading an empty FIFO;
- clear writes with only high bits set;
- a receive arrival in the same cycle as a receive-bit clear, which pins down set-over-clear priority;
- writes to read-only words, which show that those stores are really read-only.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int IRQ_W   = 11;
  localparam int NUM_CFG = 7;

  // word indices (byte offset / 4)
  localparam int W_DATA  = 0;
  localparam int W_RSR   = 1;
  localparam int W_FLAG  = 6;
  localparam int W_MASK  = 14;
  localparam int W_RIS   = 15;
  localparam int W_MIS   = 16;
  localparam int W_CLR   = 17;
  localparam int W_ID_LO = 'h3F8;
  localparam int W_ID_HI = 'h3FF;

  localparam int ST_TX = 5;
  localparam int ST_RX = 4;

  localparam int FL_TXFE = 7;
  localparam int FL_RXFF = 6;
  localparam int FL_RXFE = 4;

  // storage slot of a configuration word, -1 when not one
  function automatic int cfg_slot(input int widx);
    case (widx)
      8:       return 0;
      9:       return 1;
      10:      return 2;
      11:      return 3;
      12:      return 4;
      13:      return 5;
      18:      return 6;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0:    return 8'h11;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             push_ok
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl import uart_regif_pkg::*; #(
  parameter int W = IRQ_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         clr_we,
  input  logic [W-1:0] clr_wdata,
  input  logic         set_rx,
  input  logic         clr_rx,
  input  logic         set_tx,
  output logic [W-1:0] ris,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] ris_d;

  // clears first, hardware sets last so a set always wins
  always_comb begin
    ris_d = ris & ~(clr_we ? clr_wdata : '0);
    if (clr_rx) ris_d[ST_RX] = 1'b0;
    if (set_rx) ris_d[ST_RX] = 1'b1;
    if (set_tx) ris_d[ST_TX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ris  <= '0;
      mask <= '0;
    end else begin
      ris <= ris_d;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign irq = |(ris & mask);
endmodule

// File: rtl/uart_rd_mux.sv
module uart_rd_mux import uart_regif_pkg::*; #(
  parameter int WIDX_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                      aligned,
  input  logic [WIDX_W-1:0]         widx,
  input  logic [7:0]                fifo_head,
  input  logic                      fifo_empty,
  input  logic                      fifo_full,
  input  logic [IRQ_W-1:0]          ris,
  input  logic [IRQ_W-1:0]          mask,
  input  logic [NUM_CFG*DATA_W-1:0] cfg_flat,
  output logic [DATA_W-1:0]         rdata
);
  logic [8:0] flags;
  int         slot;

  always_comb begin
    flags          = '0;
    flags[FL_TXFE] = 1'b1;
    flags[FL_RXFF] = fifo_full;
    flags[FL_RXFE] = fifo_empty;
  end

  always_comb begin
    rdata = '0;
    slot  = cfg_slot(int'(widx));
    if (!aligned) begin
      rdata = '0;
    end else if (slot >= 0) begin
      rdata = cfg_flat[slot*DATA_W +: DATA_W];
    end else if (int'(widx) >= W_ID_LO && int'(widx) <= W_ID_HI) begin
      rdata = DATA_W'(id_byte(widx[2:0]));
    end else begin
      case (int'(widx))
        W_DATA:  rdata = fifo_empty ? '0 : DATA_W'(fifo_head);
        W_FLAG:  rdata = DATA_W'(flags);
        W_MASK:  rdata = DATA_W'(mask);
        W_RIS:   rdata = DATA_W'(ris);
        W_MIS:   rdata = DATA_W'(ris & mask);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif import uart_regif_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              irq
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

  logic [WIDX_W-1:0]         widx;
  logic                      aligned;
  logic                      wr_data, rd_pop, wr_mask, wr_clr;
  logic [7:0]                fifo_head;
  logic [CNT_W-1:0]          fifo_cnt;
  logic                      fifo_empty, fifo_full, push_ok, clr_rx;
  logic [IRQ_W-1:0]          ris_q, mask_q;
  logic [DATA_W-1:0]         cfg_q [NUM_CFG];
  logic [NUM_CFG*DATA_W-1:0] cfg_flat;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_data = bus_wr && aligned && (int'(widx) == W_DATA);
  assign rd_pop  = bus_rd && aligned && (int'(widx) == W_DATA);
  assign wr_mask = bus_wr && aligned && (int'(widx) == W_MASK);
  assign wr_clr  = bus_wr && aligned && (int'(widx) == W_CLR);

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_valid), .pop(rd_pop), .din(rx_byte),
    .dout(fifo_head), .count(fifo_cnt), .empty(fifo_empty), .full(fifo_full),
    .push_ok(push_ok)
  );

  // a pop that takes the last byte with no arrival alongside empties the queue
  assign clr_rx = rd_pop && (fifo_cnt == CNT_W'(1)) && !push_ok;

  uart_irq_ctl #(.W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_we(wr_mask), .mask_wdata(bus_wdata[IRQ_W-1:0]),
    .clr_we(wr_clr), .clr_wdata(bus_wdata[IRQ_W-1:0]),
    .set_rx(push_ok), .clr_rx(clr_rx), .set_tx(wr_data),
    .ris(ris_q), .mask(mask_q), .irq(irq)
  );

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[g] <= '0;
      else if (bus_wr && aligned && cfg_slot(int'(widx)) == g) cfg_q[g] <= bus_wdata;
    end
    assign cfg_flat[g*DATA_W +: DATA_W] = cfg_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= wr_data;
      if (wr_data) tx_byte <= bus_wdata[7:0];
    end
  end

  uart_rd_mux #(.WIDX_W(WIDX_W), .DATA_W(DATA_W)) u_rd (
    .aligned(aligned), .widx(widx), .fifo_head(fifo_head),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .ris(ris_q), .mask(mask_q), .cfg_flat(cfg_flat), .rdata(bus_rdata)
  );
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk import uart_regif_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tx_valid,
  input logic              irq,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic              fifo_full,
  input logic [IRQ_W-1:0]  ris_q,
  input logic              push_ok,
  input logic              rd_pop,
  input logic              wr_data,
  input logic              wr_mask,
  input logic              wr_clr
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fifo_full && !rd_pop) |=> (fifo_cnt == CNT_W'(FIFO_DEPTH)));

  assert_rx_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (ris_q[ST_RX] && fifo_cnt != '0));

  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && fifo_cnt == '0) |-> (bus_rdata == '0));

  assert_tx_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (tx_valid && ris_q[ST_TX]));

  assert_clear_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !push_ok) |=> ((ris_q & $past(bus_wdata[IRQ_W-1:0])) == '0));

  assert_mask_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && bus_wdata[IRQ_W-1:0] == '0) |=> !irq);
endmodule

bind uart_regif uart_regif_chk #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .tx_valid(tx_valid), .irq(irq), .fifo_cnt(fifo_cnt),
  .fifo_full(fifo_full), .ris_q(ris_q), .push_ok(push_ok), .rd_pop(rd_pop),
  .wr_data(wr_data), .wr_mask(wr_mask), .wr_clr(wr_clr)
);

// File: tb/uart_regif_tb.sv
`timescale 1ns/1ps
module uart_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model
  logic [7:0]  mq [16];
  int          mcnt = 0;
  logic [10:0] mris = '0;
  logic [10:0] mmask = '0;

  always #10 clk = ~clk;

  uart_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  function automatic logic [31:0] exp_flags(input int cnt);
    return 32'h80 | ((cnt == 16) ? 32'h40 : 32'h0) | ((cnt == 0) ? 32'h10 : 32'h0);
  endfunction

  function automatic logic [7:0] exp_id(input int k);
    logic [7:0] t [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (mcnt < 16) begin
      mq[mcnt] = b; mcnt++;
      mris[4] = 1'b1;
    end
  endtask

  task automatic read_data(input string req);
    logic [31:0] d;
    logic [31:0] e;
    bus_read(12'h000, d);
    e = 0;
    if (mcnt > 0) begin
      e = {24'h0, mq[0]};
      for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
      mcnt--;
      if (mcnt == 0) mris[4] = 1'b0;
    end
    check(req, d, e);
  endtask

  task automatic write_tx(input logic [31:0] w);
    bus_write(12'h000, w);
    mris[5] = 1'b1;
    check("R6 tx_valid", {31'h0, tx_valid}, 32'h1);
    check("R6 tx_byte", {24'h0, tx_byte}, {24'h0, w[7:0]});
    @(negedge clk);
    check("R6 tx single cycle", {31'h0, tx_valid}, 32'h0);
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    bus_read(12'h03C, d);
    check({req, " ris"}, d, {21'h0, mris});
    bus_read(12'h040, d);
    check({req, " mis"}, d, {21'h0, mris & mmask});
    bus_read(12'h018, d);
    check({req, " flags"}, d, exp_flags(mcnt));
    check({req, " irq R9"}, {31'h0, irq}, {31'h0, |(mris & mmask)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] cv [7];
    logic [11:0] cfg_off [7] = '{12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h048};
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    bus_read(12'h018, d); check("R1 flags", d, 32'h90);
    bus_read(12'h03C, d); check("R1 ris", d, 32'h0);
    bus_read(12'h038, d); check("R1 mask", d, 32'h0);
    bus_read(12'h040, d); check("R1 mis", d, 32'h0);
    for (int i = 0; i < 7; i++) begin
      bus_read(cfg_off[i], d); check("R1 cfg", d, 32'h0);
    end

    // R2 configuration storage
    for (int i = 0; i < 7; i++) begin
      cv[i] = $urandom;
      bus_write(cfg_off[i], cv[i]);
    end
    for (int i = 0; i < 7; i++) begin
      bus_read(cfg_off[i], d); check("R2 cfg readback", d, cv[i]);
    end

    // R11 identification and unmapped
    for (int i = 0; i < 4; i++) begin
      bus_read(12'hFE0 + 12'(4*i), d); check("R11 id lo", d, {24'h0, exp_id(i)});
      bus_read(12'hFF0 + 12'(4*i), d); check("R11 id hi", d, {24'h0, exp_id(i+4)});
    end
    bus_read(12'h04C, d); check("R11 unmapped", d, 32'h0);
    bus_read(12'h800, d); check("R11 unmapped", d, 32'h0);
    bus_read(12'hFE1, d); check("R11 misaligned", d, 32'h0);
    bus_write(12'h026, 32'hDEADBEEF);
    bus_read(12'h024, d); check("R11 misaligned write", d, cv[1]);

    // R5 empty read
    read_data("R5 empty read");

    // R10 ignored writes
    bus_write(12'h018, 32'hFFFF_FFFF);
    bus_write(12'h03C, 32'h7FF);
    bus_write(12'h040, 32'h7FF);
    bus_write(12'h004, 32'hFFFF_FFFF);
    bus_read(12'h004, d); check("R10 rsr reads 0", d, 32'h0);
    bus_read(12'h044, d); check("R8 clear reads 0", d, 32'h0);
    check_state("R10 after ignored writes");

    // R7 mask truncation
    bus_write(12'h038, 32'hFFFF_FFFF); mmask = 11'h7FF;
    bus_read(12'h038, d); check("R7 mask bits", d, 32'h7FF);

    // R3 fill past depth, R4
    for (int i = 0; i < 17; i++) push_byte(8'(8'hA0 + i));
    check_state("R3 R4 full");
    for (int i = 0; i < 16; i++) read_data("R5 fifo order");
    check_state("R5 drained");
    read_data("R3 overflow byte dropped");

    // R6 transmit
    write_tx(32'h1234_5678);
    check_state("R6 status");

    // R8 high bits ignored, then real clear
    bus_write(12'h044, 32'hFFFF_F800);
    check_state("R8 high bits");
    bus_write(12'h044, 32'h20); mris[5] = 1'b0;
    check_state("R8 tx cleared");

    // R8 same-cycle receive and clear of the receive bit
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h5A;
    bus_addr = 12'h044; bus_wdata = 32'h10; bus_wr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_wr = 1'b0;
    mq[mcnt] = 8'h5A; mcnt++; mris[4] = 1'b1;
    check_state("R8 set wins");
    read_data("R5 after set-wins");

    // R9 mask off
    bus_write(12'h000, 32'h0); mris[5] = 1'b1;
    bus_write(12'h038, 32'h0); mmask = '0;
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    bus_write(12'h038, 32'h20); mmask = 11'h20;
    check("R9 irq unmasked", {31'h0, irq}, 32'h1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [31:0] w;
      op = $urandom_range(0, 5);
      w = $urandom;
      case (op)
        0, 1: push_byte(w[7:0]);
        2: read_data("R5 random read");
        3: begin bus_write(12'h038, w); mmask = w[10:0]; end
        4: begin bus_write(12'h044, w); mris = mris & ~w[10:0]; end
        default: write_tx(w);
      endcase
      check("R9 irq random", {31'h0, irq}, {31'h0, |(mris & mmask)});
      if (n % 8 == 0) check_state("R4 R7 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule